// File: doc/BRIEF.md
# Clock Post-Divider with Glitch-Free Output Gating

This block produces the final output clock of a frequency synthesizer. It picks one of two clock sources, either the synthesizer (PLL) clock or the reference clock, and divides it by a power of two from 1 to 128. The divided clock then passes through a gate driven by one active-low control pin. The gate works in one of two modes. In output-enable mode a low pin floats the output while both sources keep running. In power-down mode a low pin also asks the oscillator and PLL to stop.

The block runs on one fast system clock. Each source is presented as a one-cycle tick on every edge of that source, so each tick is one half-period of the source. Disabling is either immediate, through a path that skips the pin synchronizer, or waits for the next falling edge of the divided clock. Enabling always waits for a falling edge, and after a power-down it also waits for the lock input. A new source or ratio is taken only while the divided clock is low. There is no data stream, so the ports are plain control and status pins with no valid/ready handshake. In immediate-disable mode a low pulse on the control pin must last at least SYNC_STAGES+1 system clocks.

Top module: `clkdiv_gate`

## Requirements
- R1: With cfg_ratio_i = k (0..7), the divided clock is high for 2^k source ticks and low for 2^k source ticks.
- R2: cfg_src_i = 0 selects pll_tick_i as the source and cfg_src_i = 1 selects ref_tick_i.
- R3: A change of cfg_src_i or cfg_ratio_i is applied only while the divided clock is low, so every high pulse on clk_o has the full width of either the old setting or the new one.
- R4: After reset clk_o is 0, pd_req_o is 0 and, in output-enable mode (cfg_pd_mode_i = 0), drive_en_o is 0. The output is enabled at the first falling edge of the divided clock once the synchronized control pin is high.
- R5: With cfg_async_i = 0, a low ctl_n_i lets the current high pulse finish at full width. The output stops at that falling edge and stays low.
- R6: With cfg_async_i = 1, a low ctl_n_i forces clk_o to 0 in the same cycle, whatever the clock phase. In output-enable mode it also forces drive_en_o to 0 in that cycle.
- R7: Re-enabling always takes effect at a falling edge of the divided clock, in both timing modes. drive_en_o rises while clk_o is low, and the first high pulse has full width.
- R8: In output-enable mode (cfg_pd_mode_i = 0) pd_req_o is never asserted and drive_en_o is 0 while the output is disabled. The divider keeps running, so the first rising edge after re-enable comes within 30 cycles at ratio 3 with a tick every cycle.
- R9: In power-down mode (cfg_pd_mode_i = 1) a low control pin asserts pd_req_o and stops the divider. clk_o is held at 0 while drive_en_o stays 1.
- R10: When the control pin returns high in power-down mode, pd_req_o drops within 6 cycles. clk_o stays low until lock_i is 1 and is then enabled at the next falling edge of the divided clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_tick_i | input | 1 | One-cycle pulse on each edge of the PLL clock |
| ref_tick_i | input | 1 | One-cycle pulse on each edge of the reference clock |
| cfg_src_i | input | 1 | Source select: 0 PLL, 1 reference |
| cfg_ratio_i | input | RATIO_W (3) | log2 of the divide ratio |
| cfg_pd_mode_i | input | 1 | 0 output-enable mode, 1 power-down mode |
| cfg_async_i | input | 1 | 0 disable at falling edge, 1 immediate disable |
| ctl_n_i | input | 1 | Active-low control pin; high means run |
| lock_i | input | 1 | Sources locked and ready |
| clk_o | output | 1 | Gated divided clock |
| drive_en_o | output | 1 | Drive enable for the tristate output pad |
| pd_req_o | output | 1 | Request to power down oscillator and PLL |

## Verification
A wrong divider count or a stale shadow setting shows up as a high or low pulse of the wrong width on clk_o within one output period. A gate state machine stuck in the wrong state shows up as clk_o running while disabled, or as a first pulse cut short. Both are visible within a couple of output periods of the control pin changing. A wrong power-down or lock sequence shows up on pd_req_o within a few cycles, or as clk_o toggling before lock_i rises. The directed scenarios time each pulse at the ports to catch these cases.

// File: rtl/cdg_pkg.sv
package cdg_pkg;

  typedef enum logic [1:0] {
    GATE_OFF       = 2'd0,
    GATE_WAIT_LOCK = 2'd1,
    GATE_ARMED     = 2'd2,
    GATE_RUN       = 2'd3
  } gate_state_t;

  typedef enum logic {
    SRC_PLL = 1'b0,
    SRC_REF = 1'b1
  } src_sel_t;

endpackage

// File: rtl/cdg_sync.sv
module cdg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= {STAGES{RST_VAL}};
    end else begin
      shift_q <= {shift_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = shift_q[STAGES-1];

endmodule

// File: rtl/cdg_divider.sv
module cdg_divider
  import cdg_pkg::*;
#(
  parameter int MAX_LOG2 = 7,
  parameter int RATIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_i,
  input  logic               pll_tick_i,
  input  logic               ref_tick_i,
  input  logic               src_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               phase_o,
  output logic               fall_o
);

  localparam int CNT_W = (MAX_LOG2 < 1) ? 1 : MAX_LOG2;
  localparam logic [RATIO_W-1:0] RATIO_MAX = RATIO_W'(MAX_LOG2);

  src_sel_t           src_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] ratio_clamped;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   limit;
  logic               phase_q;
  logic               sel_tick;
  logic               at_limit;

  // Clamp the requested ratio to the largest one the counter can hold.
  always_comb begin
    ratio_clamped = (ratio_i > RATIO_MAX) ? RATIO_MAX : ratio_i;
  end

  // Half-period length in ticks, minus one.
  always_comb begin
    limit = CNT_W'((32'd1 << ratio_q) - 32'd1);
  end

  always_comb begin
    sel_tick = (src_q == SRC_PLL) ? pll_tick_i : ref_tick_i;
  end

  // ">=" lets a shrinking ratio end the half period at once, never wrap.
  assign at_limit = (cnt_q >= limit);
  assign fall_o   = phase_q & sel_tick & at_limit & ~halt_i;
  assign phase_o  = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= SRC_PLL;
      ratio_q <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (halt_i) begin
      src_q   <= src_sel_t'(src_i);
      ratio_q <= ratio_clamped;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      // Shadow settings reload only during the low half period.
      if (!phase_q) begin
        src_q   <= src_sel_t'(src_i);
        ratio_q <= ratio_clamped;
      end
      if (sel_tick) begin
        if (at_limit) begin
          cnt_q   <= '0;
          phase_q <= ~phase_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/cdg_gate_fsm.sv
module cdg_gate_fsm
  import cdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_req_i,
  input  logic        fall_i,
  input  logic        async_i,
  input  logic        pd_mode_i,
  input  logic        lock_i,
  output logic        en_o,
  output logic        pd_req_o,
  output gate_state_t state_o
);

  gate_state_t state_q;
  gate_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_RUN: begin
        if (!run_req_i && (async_i || fall_i)) state_d = GATE_OFF;
      end
      GATE_OFF: begin
        if (run_req_i) state_d = pd_mode_i ? GATE_WAIT_LOCK : GATE_ARMED;
      end
      GATE_WAIT_LOCK: begin
        if (!run_req_i)  state_d = GATE_OFF;
        else if (lock_i) state_d = GATE_ARMED;
      end
      GATE_ARMED: begin
        if (!run_req_i)  state_d = GATE_OFF;
        else if (fall_i) state_d = GATE_RUN;
      end
      default: state_d = GATE_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GATE_OFF;
    else        state_q <= state_d;
  end

  assign en_o     = (state_q == GATE_RUN);
  assign pd_req_o = (state_q == GATE_OFF) && pd_mode_i;
  assign state_o  = state_q;

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate
  import cdg_pkg::*;
#(
  parameter int MAX_LOG2    = 7,
  parameter int SYNC_STAGES = 2,
  localparam int RATIO_W    = $clog2(MAX_LOG2 + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pll_tick_i,
  input  logic               ref_tick_i,
  input  logic               cfg_src_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic               cfg_pd_mode_i,
  input  logic               cfg_async_i,
  input  logic               ctl_n_i,
  input  logic               lock_i,
  output logic               clk_o,
  output logic               drive_en_o,
  output logic               pd_req_o
);

  logic        run_req;
  logic        div_phase;
  logic        div_fall;
  logic        gate_en;
  logic        async_kill;
  gate_state_t gate_state;

  cdg_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b0)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (ctl_n_i),
    .q_o   (run_req)
  );

  cdg_divider #(
    .MAX_LOG2 (MAX_LOG2),
    .RATIO_W  (RATIO_W)
  ) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (pd_req_o),
    .pll_tick_i (pll_tick_i),
    .ref_tick_i (ref_tick_i),
    .src_i      (cfg_src_i),
    .ratio_i    (cfg_ratio_i),
    .phase_o    (div_phase),
    .fall_o     (div_fall)
  );

  cdg_gate_fsm u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_req_i (run_req),
    .fall_i    (div_fall),
    .async_i   (cfg_async_i),
    .pd_mode_i (cfg_pd_mode_i),
    .lock_i    (lock_i),
    .en_o      (gate_en),
    .pd_req_o  (pd_req_o),
    .state_o   (gate_state)
  );

  // Immediate path: the raw pin skips the synchronizer.
  assign async_kill = cfg_async_i & ~ctl_n_i;

  assign clk_o      = div_phase & gate_en & ~async_kill;
  assign drive_en_o = cfg_pd_mode_i | (gate_en & ~async_kill);

endmodule

// File: rtl/cdg_checker.sv
module cdg_checker
  import cdg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_async_i,
  input logic        cfg_pd_mode_i,
  input logic        ctl_n_i,
  input logic        clk_o,
  input logic        drive_en_o,
  input logic        pd_req_o,
  input logic        div_phase,
  input gate_state_t gate_state
);

  // R5: in edge-aligned mode the output only falls with the divider phase.
  p_fall_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async_i && $fell(clk_o)) |-> $fell(div_phase));

  // R7: the output never starts in the middle of a high phase.
  p_rise_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_async_i && $rose(clk_o)) |-> $rose(div_phase));

  // R6: immediate disable.
  p_async_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_async_i && !ctl_n_i) |-> (!clk_o && (cfg_pd_mode_i || !drive_en_o)));

  // R8: a toggling output is always driven.
  p_drive_when_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_o |-> drive_en_o);

  // R9: power-down holds the pad low and driven.
  p_pd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req_o |-> (!clk_o && drive_en_o));

  // R9: divider is stopped while power-down is requested.
  p_pd_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req_o |=> !div_phase);

  // R10: no clock while waiting for lock.
  p_lock_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_state == GATE_WAIT_LOCK) |-> !clk_o);

endmodule

bind clkdiv_gate cdg_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_async_i   (cfg_async_i),
  .cfg_pd_mode_i (cfg_pd_mode_i),
  .ctl_n_i       (ctl_n_i),
  .clk_o         (clk_o),
  .drive_en_o    (drive_en_o),
  .pd_req_o      (pd_req_o),
  .div_phase     (div_phase),
  .gate_state    (gate_state)
);

// File: tb/clkdiv_gate_test.sv
`timescale 1ns/1ps
module clkdiv_gate_test;

  localparam int GUARD = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_tick = 1'b0;
  logic       ref_tick = 1'b0;
  logic       cfg_src = 1'b0;
  logic [2:0] cfg_ratio = 3'd0;
  logic       cfg_pd_mode = 1'b0;
  logic       cfg_async = 1'b0;
  logic       ctl_n = 1'b1;
  logic       lock = 1'b1;
  logic       clk_o;
  logic       drive_en_o;
  logic       pd_req_o;

  int total = 0;
  int bad = 0;
  int pll_every = 1;
  int ref_every = 3;
  int pc = 0;
  int rc = 0;
  bit oe_pd_seen = 1'b0;

  always #10 clk = ~clk;

  clkdiv_gate uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .pll_tick_i    (pll_tick),
    .ref_tick_i    (ref_tick),
    .cfg_src_i     (cfg_src),
    .cfg_ratio_i   (cfg_ratio),
    .cfg_pd_mode_i (cfg_pd_mode),
    .cfg_async_i   (cfg_async),
    .ctl_n_i       (ctl_n),
    .lock_i        (lock),
    .clk_o         (clk_o),
    .drive_en_o    (drive_en_o),
    .pd_req_o      (pd_req_o)
  );

  // Source tick generators.
  always @(negedge clk) begin
    pc = pc + 1;
    if (pc >= pll_every) begin pc = 0; pll_tick <= 1'b1; end
    else pll_tick <= 1'b0;
    rc = rc + 1;
    if (rc >= ref_every) begin rc = 0; ref_tick <= 1'b1; end
    else ref_tick <= 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n && !cfg_pd_mode && pd_req_o) oe_pd_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge; ends at the first low sample after a high pulse.
  task automatic next_pulse(output int lo, output int hi);
    int guard = 0;
    lo = 0; hi = 0;
    while (clk_o && guard < GUARD) begin @(negedge clk); guard++; end
    while (!clk_o && guard < GUARD) begin lo++; @(negedge clk); guard++; end
    while (clk_o && guard < GUARD) begin hi++; @(negedge clk); guard++; end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(clk_o == 1'b0, "R4 clk_o after reset", int'(clk_o), 0);
    check(drive_en_o == 1'b0, "R4 drive_en_o after reset", int'(drive_en_o), 0);
    check(pd_req_o == 1'b0, "R4 pd_req_o after reset", int'(pd_req_o), 0);
  endtask

  task automatic test_ratio(input bit src, input int k, input int tick_len, input string req);
    int lo, hi, w;
    cfg_src = src;
    cfg_ratio = 3'(k);
    next_pulse(lo, hi);
    next_pulse(lo, hi);
    next_pulse(lo, hi);
    w = tick_len * (1 << k);
    check(hi == w, {req, " high width"}, hi, w);
    check(lo == w, {req, " low width"}, lo, w);
  endtask

  task automatic test_change_mid_high();
    int lo, hi, guard;
    cfg_src = 1'b0;
    cfg_ratio = 3'd1;
    next_pulse(lo, hi);
    next_pulse(lo, hi);
    guard = 0;
    while (!clk_o && guard < GUARD) begin @(negedge clk); guard++; end
    cfg_ratio = 3'd4;
    hi = 0;
    while (clk_o && guard < GUARD) begin hi++; @(negedge clk); guard++; end
    check(hi == 2, "R3 pulse during change keeps old width", hi, 2);
    next_pulse(lo, hi);
    check(hi == 16, "R3 next pulse has new width", hi, 16);
  endtask

  task automatic test_sync_disable();
    int lo, hi, guard;
    bit seen_hi;
    cfg_async = 1'b0;
    cfg_ratio = 3'd3;
    next_pulse(lo, hi);
    next_pulse(lo, hi);
    guard = 0;
    while (!clk_o && guard < GUARD) begin @(negedge clk); guard++; end
    hi = 1;
    while (guard < GUARD) begin
      @(negedge clk); guard++;
      if (!clk_o) break;
      hi++;
      if (hi == 2) ctl_n = 1'b0;
    end
    check(hi == 8, "R5 last pulse full width", hi, 8);
    seen_hi = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_o) seen_hi = 1'b1;
    end
    check(!seen_hi, "R5 output stays low", int'(seen_hi), 0);
    check(drive_en_o == 1'b0, "R8 output floated while disabled", int'(drive_en_o), 0);
  endtask

  task automatic test_enable(input string mode);
    int lo, hi, n;
    ctl_n = 1'b1;
    n = 0;
    while (!drive_en_o && n < GUARD) begin @(negedge clk); n++; end
    check(clk_o == 1'b0, {"R7 drive_en rises with clock low ", mode}, int'(clk_o), 0);
    next_pulse(lo, hi);
    check(hi == 8, {"R7 first pulse full width ", mode}, hi, 8);
    check(n + lo <= 30, {"R8 quick return ", mode}, n + lo, 30);
  endtask

  task automatic test_async_disable();
    int lo, hi, guard;
    bit seen_hi;
    cfg_async = 1'b1;
    next_pulse(lo, hi);
    guard = 0;
    while (!clk_o && guard < GUARD) begin @(negedge clk); guard++; end
    @(negedge clk);
    ctl_n = 1'b0;
    #1;
    check(clk_o == 1'b0, "R6 clk_o drops at once", int'(clk_o), 0);
    check(drive_en_o == 1'b0, "R6 drive_en_o drops at once", int'(drive_en_o), 0);
    seen_hi = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_o) seen_hi = 1'b1;
    end
    check(!seen_hi, "R6 output stays low", int'(seen_hi), 0);
  endtask

  task automatic test_power_down();
    int lo, hi, n;
    bit seen_hi;
    cfg_async = 1'b0;
    cfg_pd_mode = 1'b1;
    check(!oe_pd_seen, "R8 no power-down request in OE mode", int'(oe_pd_seen), 0);
    next_pulse(lo, hi);
    ctl_n = 1'b0;
    n = 0;
    while (!pd_req_o && n < 30) begin @(negedge clk); n++; end
    check(pd_req_o == 1'b1, "R9 pd_req_o asserted", int'(pd_req_o), 1);
    check(clk_o == 1'b0, "R9 clk_o low in power-down", int'(clk_o), 0);
    check(drive_en_o == 1'b1, "R9 pad stays driven", int'(drive_en_o), 1);
    lock = 1'b0;
    repeat (20) @(negedge clk);
    ctl_n = 1'b1;
    repeat (6) @(negedge clk);
    check(pd_req_o == 1'b0, "R10 pd_req_o released", int'(pd_req_o), 0);
    seen_hi = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (clk_o) seen_hi = 1'b1;
    end
    check(!seen_hi, "R10 no clock before lock", int'(seen_hi), 0);
    lock = 1'b1;
    next_pulse(lo, hi);
    check(hi == 8, "R10 first pulse after lock full width", hi, 8);
    check(lo <= 30, "R10 enable follows lock", lo, 30);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_ratio(1'b0, 0, 1, "R1 ratio 1");
    test_ratio(1'b0, 1, 1, "R1 ratio 2");
    test_ratio(1'b0, 3, 1, "R1 ratio 8");
    test_ratio(1'b0, 7, 1, "R1 ratio 128");
    test_ratio(1'b1, 2, 3, "R2 reference source");
    test_change_mid_high();
    test_sync_disable();
    test_enable("edge mode");
    test_async_disable();
    test_enable("immediate mode");
    test_power_down();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule